// File: doc/BRIEF.md
# Windowed Slave Bitstream Receiver

This block takes in a serial coded bitstream that an external source drives. The source supplies five signals: a bit clock, a data bit, a window qualifier that marks valid bits, a per-bit error flag and a frame sync. All five are brought into the system clock domain through a two-flop synchronizer. A bit is taken on each rising edge of the synchronized bit clock. Bits outside the window are dropped. Frame starts are found from leading edges of the sync signal, and the valid bits are packed into bytes. Each byte comes out with an OR-combined error flag and a marker that shows whether it opens a frame.

Alignment to the frame does not depend on where the sync edge falls relative to the window. If the edge arrives during a window-low stretch, the first bit after the window reopens starts the frame. A programmable bit budget watches for a frame sync that has gone missing.

Top module: `slv_bitstream_rx`

## Requirements
- R1: The serial inputs pass through two synchronizing flops. A bit is taken only on a low-to-high transition of the synchronized bit clock. Between transitions, no internal byte state changes.
- R2: A bit taken while the window input is 0 is discarded. Neither its data nor its error flag reaches any output byte.
- R3: `byte_err` is the OR of the error flags of the eight valid bits that make up the byte.
- R4: A leading edge of sync is a taken bit with sync 1 whose previously taken bit had sync 0. If the window is 1 on that bit, that same bit is frame bit 1.
- R5: If the leading edge comes on a bit with the window at 0, the next bit taken with the window at 1 is frame bit 1. This holds even if sync is still high by then.
- R6: Bytes are packed MSB first, so frame bit 1 lands in bit 7. `byte_vld` pulses for exactly one system clock cycle after the eighth valid bit. `byte_sof` is 1 only on a byte whose bit 7 is frame bit 1.
- R7: A frame bit 1 that arrives part way through a byte drops the partial byte and restarts packing at that bit.
- R8: After reset, no byte is produced until the first frame bit 1.
- R9: `sync_lost` goes to 1 on a valid bit, other than frame bit 1, that arrives once `max_gap` valid bits have been counted since the last frame bit 1. The count includes frame bit 1 itself. Frame bit 1 clears `sync_lost`.
- R10: While `rst_n` is 0, `byte_vld`, `byte_sof`, `byte_err` and `sync_lost` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk | input | 1 | Serial bit clock from the source |
| ser_dat | input | 1 | Serial data bit |
| ser_win | input | 1 | Window qualifier, 1 marks a valid bit |
| ser_err | input | 1 | Per-bit unreliability flag |
| ser_sync | input | 1 | Frame sync, leading edge marks a frame start |
| max_gap | input | GAP_W | Largest number of valid bits allowed per frame |
| byte_vld | output | 1 | One-cycle strobe for a finished byte |
| byte_dat | output | 8 | Finished byte, first received bit in bit 7 |
| byte_err | output | 1 | OR of the error flags of the byte's bits |
| byte_sof | output | 1 | Byte begins with frame bit 1 |
| sync_lost | output | 1 | Sync edge missing for more than `max_gap` valid bits |

## Verification
Two cases are the hardest to reach from the ports. One is a sync edge that falls inside a window-low stretch while sync then stays high into the next valid bits. The other is a new frame start that cuts into a half-filled byte. The stimulus table includes both. It places the sync rise two bits before the window reopens, with sync held high across the reopening. It also feeds two stray valid bits just before a fresh sync edge. Window-low bits in the table carry error flags and data ones, so that a leak would show in the packed bytes.

// File: rtl/slv_bitstream_rx.sv
module slv_bitstream_rx #(
  parameter int GAP_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk,
  input  logic             ser_dat,
  input  logic             ser_win,
  input  logic             ser_err,
  input  logic             ser_sync,
  input  logic [GAP_W-1:0] max_gap,
  output logic             byte_vld,
  output logic [BYTE_W-1:0] byte_dat,
  output logic             byte_err,
  output logic             byte_sof,
  output logic             sync_lost
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  logic [4:0] sy1, sy2;
  logic       ck_d, sync_d, pend, aligned, sof_p, eacc;
  logic [BYTE_W-1:0] acc;
  logic [CNT_W-1:0]  cnt;
  logic [GAP_W-1:0]  gap;

  logic ck_s, sync_s, err_s, win_s, dat_s;
  logic bit_ev, armed, start, vbit, fill, last;

  assign {ck_s, sync_s, err_s, win_s, dat_s} = sy2;
  assign bit_ev = ck_s & ~ck_d;
  assign armed  = (sync_s & ~sync_d) | pend;
  assign vbit   = bit_ev & win_s;
  assign start  = vbit & armed;
  assign fill   = vbit & ~start & aligned;
  assign last   = fill & (cnt == CNT_W'(BYTE_W - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sy1 <= '0;
      sy2 <= '0;
      ck_d <= 1'b0;
    end else begin
      sy1 <= {ser_clk, ser_sync, ser_err, ser_win, ser_dat};
      sy2 <= sy1;
      ck_d <= ck_s;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_d    <= 1'b0;
      pend      <= 1'b0;
      aligned   <= 1'b0;
      sof_p     <= 1'b0;
      eacc      <= 1'b0;
      acc       <= '0;
      cnt       <= '0;
      gap       <= '0;
      sync_lost <= 1'b0;
      byte_vld  <= 1'b0;
      byte_dat  <= '0;
      byte_err  <= 1'b0;
      byte_sof  <= 1'b0;
    end else begin
      byte_vld <= 1'b0;
      if (bit_ev) begin
        sync_d <= sync_s;
        pend   <= armed & ~win_s;
      end
      if (start) begin
        aligned   <= 1'b1;
        acc       <= {{(BYTE_W-1){1'b0}}, dat_s};
        cnt       <= CNT_W'(1);
        eacc      <= err_s;
        sof_p     <= 1'b1;
        gap       <= GAP_W'(1);
        sync_lost <= 1'b0;
      end else if (vbit) begin
        if (gap == max_gap) sync_lost <= 1'b1;
        else                gap <= gap + 1'b1;
      end
      if (fill) begin
        acc  <= {acc[BYTE_W-2:0], dat_s};
        cnt  <= cnt + 1'b1;
        eacc <= eacc | err_s;
      end
      if (last) begin
        byte_vld <= 1'b1;
        byte_dat <= {acc[BYTE_W-2:0], dat_s};
        byte_err <= eacc | err_s;
        byte_sof <= sof_p;
        cnt      <= '0;
        eacc     <= 1'b0;
        sof_p    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/slv_bitstream_rx_chk.sv
module slv_bitstream_rx_chk #(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bit_ev,
  input logic              win_s,
  input logic              start,
  input logic [BYTE_W-1:0] acc,
  input logic              eacc,
  input logic [CNT_W-1:0]  cnt,
  input logic              byte_vld,
  input logic              byte_sof,
  input logic              byte_err,
  input logic              sync_lost
);
  AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |=> !byte_vld); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_ev |=> $stable(acc) && $stable(cnt) && $stable(eacc)); // R1
  AST_WIN_LOW_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_ev && !win_s) |=> $stable(acc) && $stable(cnt) && $stable(eacc)); // R2
  AST_START_CLEARS_LOST: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !sync_lost); // R9
  AST_RESTART_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt == CNT_W'(1))); // R7
  AST_VLD_AFTER_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(byte_vld) |-> $past(bit_ev)); // R6
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!byte_vld && !byte_sof && !byte_err && !sync_lost) || !rst_n); // R10
endmodule

bind slv_bitstream_rx slv_bitstream_rx_chk #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_ev(bit_ev), .win_s(win_s), .start(start),
  .acc(acc), .eacc(eacc), .cnt(cnt), .byte_vld(byte_vld), .byte_sof(byte_sof),
  .byte_err(byte_err), .sync_lost(sync_lost)
);

// File: tb/slv_bitstream_rx_test.sv
module slv_bitstream_rx_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_win = 1'b0, ser_err = 1'b0, ser_sync = 1'b0;
  logic [15:0] max_gap = 16'd40;
  logic byte_vld, byte_err, byte_sof, sync_lost;
  logic [7:0] byte_dat;
  int checks = 0, fails = 0, nbytes = 0;
  logic [9:0] got [16];

  always #2.5 clk = ~clk;

  slv_bitstream_rx uut (.*);

  // entries: {win, sync, err, dat}
  localparam logic [3:0] STIM [40] = '{
    4'b1001, 4'b1010, 4'b1101, 4'b1110, 4'b0011, 4'b1001, 4'b1000, 4'b1000,
    4'b1001, 4'b1000, 4'b1001, 4'b1000, 4'b1000, 4'b0011, 4'b1001, 4'b1001,
    4'b1001, 4'b1001, 4'b1000, 4'b1000, 4'b0101, 4'b0110, 4'b1101, 4'b1001,
    4'b1001, 4'b1001, 4'b1000, 4'b1000, 4'b1000, 4'b1000, 4'b1001, 4'b1001,
    4'b1100, 4'b1100, 4'b1000, 4'b1000, 4'b1011, 4'b1001, 4'b1001, 4'b1001};
  // entries: {sof, err, data}
  localparam logic [9:0] EXPB [4] = '{
    {2'b11, 8'hA5}, {2'b00, 8'h3C}, {2'b10, 8'hF0}, {2'b11, 8'h0F}};

  always @(negedge clk)
    if (rst_n && byte_vld && nbytes < 16) begin
      got[nbytes] = {byte_sof, byte_err, byte_dat};
      nbytes++;
    end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic [3:0] v);
    @(negedge clk);
    {ser_win, ser_sync, ser_err, ser_dat} = v;
    repeat (3) @(negedge clk);
    ser_clk = 1'b1;
    repeat (4) @(negedge clk);
    ser_clk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R10 vld", byte_vld, 0);
    check("R10 lost", sync_lost, 0);
    check("R10 sof", byte_sof, 0);
    rst_n = 1'b1;
    // R8: valid bits with no sync edge produce nothing
    for (int i = 0; i < 12; i++) send_bit(4'b1001);
    check("R8 no bytes before frame", nbytes, 0);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 40; i++) send_bit(STIM[i]);
    check("R6 byte count", nbytes, 4);
    for (int k = 0; k < 4; k++) begin
      check("R6 R2 data", got[k][7:0], EXPB[k][7:0]);
      check("R3 R2 err", got[k][8], EXPB[k][8]);
      check("R4 R5 R7 sof", got[k][9], EXPB[k][9]);
    end
    check("R9 no loss in table", sync_lost, 0);
    // R9: 8 valid bits since last frame start; budget 8
    max_gap = 16'd8;
    send_bit(4'b0000);
    check("R9 window-low bit does not count", sync_lost, 0);
    send_bit(4'b1000);
    check("R9 loss raised", sync_lost, 1);
    send_bit(4'b1100);
    check("R9 loss cleared by frame start", sync_lost, 0);
    // R1: held bit clock with changing data gives no new bits
    ser_clk = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      ser_dat = ~ser_dat;
      ser_win = 1'b1;
    end
    ser_clk = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 no bytes without clock edges", nbytes, 4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule